// File: doc/BRIEF.md
# Rate 2/3 Trellis Encoder for 8-Phase Signalling

This block is a convolutional encoder. On each accepted transfer it takes a 2-bit input symbol and returns a 3-bit code symbol. The code symbol picks one of eight phase points in an 8-phase PSK constellation, so every two data bits become three channel bits.

The encoder keeps a small memory: the low data bit of the two most recent accepted symbols. These two bits form a four-state trellis. The high data bit passes through uncoded. The middle code bit is the low data bit XOR the low bit from two symbols back. The low code bit is the low bit from the previous symbol.

Both sides of the block use a valid/ready stream with no storage between them. The code symbol is combinational from the current input and the stored state, so it is valid in the same cycle as the input. `in_ready` simply mirrors `out_ready`. A transfer happens when `in_valid` and `out_ready` are both high, and only a transfer moves the trellis. While the consumer holds `out_ready` low, the producer must keep `in_sym` steady. The code symbol then holds as well.

Top module: `trellis_enc83`

## Requirements
- R1: An active-high synchronous `rst` returns the trellis to its all-zero state. Right after reset, input 0 gives code 0 and input 1 gives code 2.
- R2: Code bit 2 (the value-4 weight of `out_code`) equals input bit 1 (the value-2 weight of `in_sym`) in every cycle.
- R3: Code bit 1 equals input bit 0 XOR the input bit 0 of the transfer two transfers earlier. That earlier bit counts as 0 if fewer than two transfers have happened since reset.
- R4: Code bit 0 equals input bit 0 of the previous transfer, or 0 if none has happened since reset.
- R5: `out_valid` equals `in_valid`, and `out_code` reflects the `in_sym` applied in the same cycle.
- R6: `in_ready` equals `out_ready` in every cycle.
- R7: The trellis state changes only on a cycle where `in_valid` and `out_ready` are both high. Idle and stalled cycles leave it unchanged, whatever `in_sym` carries.
- R8: Feeding inputs 0,1,2,3 repeatedly from reset gives codes 0,2,5,4 for the first four symbols. From then on the codes repeat as 1,0,5,4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input symbol is present |
| in_ready | output | 1 | Encoder can take the symbol (mirrors out_ready) |
| in_sym | input | 2 | Data symbol, bit 1 uncoded, bit 0 coded |
| out_valid | output | 1 | Code symbol is present |
| out_ready | input | 1 | Consumer takes the code symbol |
| out_code | output | 3 | Code symbol, constellation point index 0..7 |

## Verification
The bound checker keeps its own two-deep record of accepted low bits. Against that record it checks every code bit in every cycle. It also checks that the handshake pins mirror each other and that a stalled symbol with steady input does not change. Only the bench scenarios show the specific code values: the two post-reset warm-up symbols, the steady 1,0,5,4 cycle, and the proof that long idle or stalled stretches with changing `in_sym` leave no mark on later codes.

// File: rtl/tce_pkg.sv
package tce_pkg;
  localparam int unsigned SYM_W  = 2;
  localparam int unsigned CODE_W = SYM_W + 1;
  localparam int unsigned MEM_W  = 2;

  // trellis state: bit 1 = low data bit one transfer ago, bit 0 = two ago
  typedef enum logic [MEM_W-1:0] {
    TS_ZERO = 2'b00,
    TS_NEW  = 2'b10,
    TS_OLD  = 2'b01,
    TS_BOTH = 2'b11
  } tce_state_e;

  typedef logic [SYM_W-1:0]  sym_t;
  typedef logic [CODE_W-1:0] code_t;
endpackage

// File: rtl/tce_state_reg.sv
module tce_state_reg
  import tce_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       advance,
  input  logic       new_bit,
  output tce_state_e state_q
);
  logic [MEM_W-1:0] hist_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      hist_q <= '0;
    end else if (advance) begin
      hist_q <= {new_bit, hist_q[MEM_W-1:1]};
    end
  end

  assign state_q = tce_state_e'(hist_q);
endmodule

// File: rtl/tce_mapper.sv
module tce_mapper
  import tce_pkg::*;
(
  input  sym_t       sym,
  input  tce_state_e state,
  output code_t      code
);
  logic [MEM_W-1:0] st;
  logic             uncoded, parity, delayed;

  always_comb begin
    st      = state;
    uncoded = sym[SYM_W-1];
    parity  = sym[0] ^ st[0];
    delayed = st[MEM_W-1];
    code    = {uncoded, parity, delayed};
  end
endmodule

// File: rtl/trellis_enc83.sv
module trellis_enc83
  import tce_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       in_valid,
  output logic       in_ready,
  input  logic [1:0] in_sym,
  output logic       out_valid,
  input  logic       out_ready,
  output logic [2:0] out_code
);
  tce_state_e state;
  logic       take;

  assign in_ready  = out_ready;
  assign out_valid = in_valid;
  assign take      = in_valid & out_ready;

  tce_state_reg u_state (
    .clk     (clk),
    .rst     (rst),
    .advance (take),
    .new_bit (in_sym[0]),
    .state_q (state)
  );

  tce_mapper u_map (
    .sym   (in_sym),
    .state (state),
    .code  (out_code)
  );
endmodule

// File: rtl/tce_checker.sv
module tce_checker (
  input logic       clk,
  input logic       rst,
  input logic       in_valid,
  input logic       in_ready,
  input logic [1:0] in_sym,
  input logic       out_valid,
  input logic       out_ready,
  input logic [2:0] out_code
);
  logic p1, p2;

  always_ff @(posedge clk) begin
    if (rst) begin
      p1 <= 1'b0;
      p2 <= 1'b0;
    end else if (in_valid && out_ready) begin
      p1 <= in_sym[0];
      p2 <= p1;
    end
  end

  AST_MSB_UNCODED: assert property (@(posedge clk) disable iff (rst)
    out_code[2] == in_sym[1]); // R2
  AST_PARITY_BIT: assert property (@(posedge clk) disable iff (rst)
    out_code[1] == (in_sym[0] ^ p2)); // R3
  AST_DELAYED_BIT: assert property (@(posedge clk) disable iff (rst)
    out_code[0] == p1); // R4
  AST_VALID_MIRROR: assert property (@(posedge clk) disable iff (rst)
    out_valid == in_valid); // R5
  AST_READY_MIRROR: assert property (@(posedge clk) disable iff (rst)
    in_ready == out_ready); // R6
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (!$stable(in_sym) || $stable(out_code))); // R7
  AST_POST_RESET: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (out_code[0] == 1'b0)); // R1
endmodule

bind trellis_enc83 tce_checker u_chk (.*);

// File: tb/trellis_enc83_tb.sv
module trellis_enc83_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [1:0] in_sym = 2'd0;
  logic       out_valid;
  logic       out_ready = 1'b0;
  logic [2:0] out_code;

  int n_chk = 0;
  int n_bad = 0;
  logic h1 = 1'b0, h2 = 1'b0;  // bench memory of accepted low bits

  always #5 clk = ~clk;

  trellis_enc83 u_dut (.*);

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // one cycle: drive at negedge, sample 1ns later, model follows posedge
  task automatic step(input logic [1:0] x, input logic v, input logic rdy,
                      input string tag, input bit chk_code);
    @(negedge clk);
    in_sym = x; in_valid = v; out_ready = rdy;
    #1;
    if (chk_code) check(tag, out_code, {x[1], x[0] ^ h2, h1});
    check("R5 out_valid", out_valid, v);
    check("R6 in_ready", in_ready, rdy);
    @(posedge clk);
    if (v && rdy) begin h2 = h1; h1 = x[0]; end
  endtask

  task automatic do_reset;
    @(negedge clk);
    rst = 1'b1; in_valid = 1'b0; out_ready = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst = 1'b0; h1 = 1'b0; h2 = 1'b0;
  endtask

  task automatic t_reset_state;
    do_reset();
    step(2'd0, 1'b1, 1'b1, "R1 first code", 1'b0);
    @(negedge clk); in_valid = 1'b0;
    do_reset();
    @(negedge clk); in_sym = 2'd0; in_valid = 1'b1; out_ready = 1'b1; #1;
    check("R1 code after reset x=0", out_code, 0);
    in_sym = 2'd1; #1;
    check("R1 code after reset x=1", out_code, 2);
    in_valid = 1'b0;
  endtask

  task automatic t_warmup_cycle;
    int exp_seq[4] = '{1, 0, 5, 4};
    do_reset();
    step(2'd0, 1'b1, 1'b1, "R8 warm-up 0", 1'b1);
    step(2'd1, 1'b1, 1'b1, "R8 warm-up 1", 1'b1);
    step(2'd2, 1'b1, 1'b1, "R8 third", 1'b1);
    step(2'd3, 1'b1, 1'b1, "R8 fourth", 1'b1);
    for (int r = 0; r < 3; r++) begin
      for (int k = 0; k < 4; k++) begin
        @(negedge clk);
        in_sym = 2'(k); in_valid = 1'b1; out_ready = 1'b1; #1;
        check("R8 steady cycle", out_code, exp_seq[k]);
        @(posedge clk);
        h2 = h1; h1 = in_sym[0];
      end
    end
  endtask

  task automatic t_msb_sweep;
    for (int k = 0; k < 8; k++)
      step(2'(k), 1'b1, 1'b1, "R2 msb passthrough", 1'b1);
  endtask

  task automatic t_stall_hold;
    logic [2:0] held;
    step(2'd1, 1'b1, 1'b1, "R7 prime", 1'b1);
    @(negedge clk); in_sym = 2'd3; in_valid = 1'b1; out_ready = 1'b0; #1;
    held = out_code;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk); #1;
      check("R7 stalled code holds", out_code, held);
    end
    for (int k = 0; k < 4; k++)
      step(2'(k), 1'b1, 1'b0, "R7 stall varied input", 1'b1);
    step(2'd2, 1'b1, 1'b1, "R7 after stall", 1'b1);
    step(2'd0, 1'b1, 1'b1, "R3 after stall", 1'b1);
  endtask

  task automatic t_idle_hold;
    step(2'd1, 1'b1, 1'b1, "R7 prime idle", 1'b1);
    for (int k = 0; k < 6; k++)
      step(2'(k), 1'b0, 1'(k & 1), "R7 idle", 1'b1);
    step(2'd0, 1'b1, 1'b1, "R4 after idle", 1'b1);
    step(2'd0, 1'b1, 1'b1, "R3 after idle", 1'b1);
  endtask

  task automatic t_walk;
    logic [7:0] lf = 8'hA5;
    for (int k = 0; k < 40; k++) begin
      lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
      step(lf[1:0], lf[2] | lf[3], lf[4] | lf[6], "R3 R4 walk", 1'b1);
    end
  endtask

  initial begin
    #200000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    t_reset_state();
    t_warmup_cycle();
    t_msb_sweep();
    t_stall_hold();
    t_idle_hold();
    t_walk();
    t_reset_state();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule